// File: doc/BRIEF.md
# Sample-End Flag Controller

This block keeps the sticky end-of-sample status for seven playback channels: six short-sample channels and one long-sample channel. Each channel's playback engine sends a one-cycle pulse when it reaches its stop address. If that channel is not masked, the pulse latches the channel's end flag. The flag then stays set until the host clears it. Neither further pulses nor elapsed time clear it.

One host control register serves both to clear and to mask the flags. Writing a 1 to a channel's bit clears that channel's flag and masks it. Writing a 0 removes the mask and leaves the flag as it is. All flags are presented together on a status byte that the host read port returns. The playback engines, interrupt generation and host bus timing are outside this block.

Top module: `endflag_ctrl`

## Requirements
- R1: On synchronous reset, the status byte becomes 0x00 and every channel is unmasked, so the control register reads as if 0x00 had been written.
- R2: An end pulse on an unmasked channel, with no clearing write in the same cycle, sets that channel's flag. The flag appears on the status byte in the cycle after the sampling clock edge.
- R3: Bit positions are the same in the control byte and the status byte. Bit 7 is the long-sample channel, and bit k (k = 0..5) is short-sample channel k+1, driven by `short_end[k]`.
- R4: A control write with a 1 in a channel's bit clears that channel's flag and masks the channel. Flags whose bits hold 0 in the same write are not changed.
- R5: A control write with a 0 in a channel's bit unmasks the channel and leaves its flag unchanged.
- R6: While a channel is masked, its end pulses do not set its flag.
- R7: A set flag remains set, through later end pulses and idle cycles, until a control write with a 1 in its bit.
- R8: If a clearing write and an end pulse for the same channel land in the same cycle, the clear wins: the flag reads 0 and the channel is masked.
- R9: Status bit 6 always reads 0, and control bit 6 has no effect.
- R10: When a write and an end pulse share a cycle, the mask in force before that write decides whether the pulse sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe, one cycle |
| ctl_wdata | input | 8 | Control byte: 1 = clear and mask, 0 = unmask |
| short_end | input | 6 | End pulses from the six short-sample channels |
| long_end | input | 1 | End pulse from the long-sample channel |
| status_rd | output | 8 | Flag status byte returned to the host |

## Verification
Every result here lands exactly one cycle after the stimulus. A write, a pulse or both are sampled on one rising edge, and the new flag and mask state is visible on `status_rd` straight after that edge. The bench changes inputs on the falling edge and compares against its model on the following falling edge, so exactly one register stage lies between stimulus and check. The effect of a mask change is observed through the response to the next pulse, one cycle later again.

// File: rtl/endflag_pkg.sv
package endflag_pkg;

    localparam int unsigned N_SHORT  = 6;
    localparam int unsigned N_CH     = N_SHORT + 1;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned LONG_POS = 7;
    localparam int unsigned LONG_IDX = N_CH - 1;

    typedef logic [N_CH-1:0]   ch_vec_t;
    typedef logic [BYTE_W-1:0] host_byte_t;

    typedef struct packed {
        logic    wr;
        ch_vec_t sel;
    } ctl_cmd_t;

    typedef struct packed {
        ch_vec_t flag;
        ch_vec_t mask;
    } ch_state_t;

    // Host byte to per-channel vector. Unused byte bits are dropped.
    function automatic ch_vec_t byte_to_ch(input host_byte_t b);
        ch_vec_t v;
        for (int i = 0; i < N_SHORT; i++) v[i] = b[i];
        v[LONG_IDX] = b[LONG_POS];
        return v;
    endfunction

    // Per-channel vector to host byte. Unused byte bits read 0.
    function automatic host_byte_t ch_to_byte(input ch_vec_t v);
        host_byte_t b;
        b = '0;
        for (int i = 0; i < N_SHORT; i++) b[i] = v[i];
        b[LONG_POS] = v[LONG_IDX];
        return b;
    endfunction

endpackage

// File: rtl/endflag_cell.sv
module endflag_cell (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic sel,
    input  logic end_pulse,
    output logic flag,
    output logic mask
);
    logic take_end;

    // The mask held before this cycle's write decides whether the pulse counts.
    assign take_end = end_pulse && !mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            mask <= 1'b0;
        end else begin
            if (wr) mask <= sel;
            if (wr && sel)   flag <= 1'b0;
            else if (take_end) flag <= 1'b1;
        end
    end
endmodule

// File: rtl/endflag_decode.sv
module endflag_decode
    import endflag_pkg::*;
(
    input  logic       ctl_wr,
    input  host_byte_t ctl_wdata,
    input  logic [N_SHORT-1:0] short_end,
    input  logic       long_end,
    output ctl_cmd_t   cmd,
    output ch_vec_t    ev
);
    always_comb begin
        cmd.wr  = ctl_wr;
        cmd.sel = byte_to_ch(ctl_wdata);
    end

    genvar g;
    generate
        for (g = 0; g < N_SHORT; g++) begin : g_short
            assign ev[g] = short_end[g];
        end
    endgenerate
    assign ev[LONG_IDX] = long_end;
endmodule

// File: rtl/endflag_pack.sv
module endflag_pack
    import endflag_pkg::*;
(
    input  ch_state_t  st,
    output host_byte_t status,
    output host_byte_t mask_byte
);
    assign status    = ch_to_byte(st.flag);
    assign mask_byte = ch_to_byte(st.mask);
endmodule

// File: rtl/endflag_ctrl.sv
module endflag_ctrl
    import endflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic [5:0] short_end,
    input  logic       long_end,
    output logic [7:0] status_rd
);
    ctl_cmd_t   cmd;
    ch_vec_t    ev;
    ch_state_t  st;
    host_byte_t mask_byte;

    endflag_decode u_decode (
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .short_end (short_end),
        .long_end  (long_end),
        .cmd       (cmd),
        .ev        (ev)
    );

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_cell
            endflag_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .wr        (cmd.wr),
                .sel       (cmd.sel[c]),
                .end_pulse (ev[c]),
                .flag      (st.flag[c]),
                .mask      (st.mask[c])
            );
        end
    endgenerate

    endflag_pack u_pack (
        .st        (st),
        .status    (status_rd),
        .mask_byte (mask_byte)
    );
endmodule

// File: rtl/endflag_ctrl_chk.sv
module endflag_ctrl_chk
    import endflag_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic [5:0] short_end,
    input logic       long_end,
    input logic [7:0] status_rd,
    input logic [7:0] mask_byte
);
    localparam logic [7:0] USED = 8'hBF;

    logic [7:0] ev_byte;
    logic [7:0] clr_byte;
    logic [7:0] arm_byte;

    assign ev_byte  = {long_end, 1'b0, short_end};
    assign clr_byte = ctl_wr ? (ctl_wdata & USED) : 8'h00;
    assign arm_byte = ev_byte & ~mask_byte & ~clr_byte;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (status_rd == 8'h00 && mask_byte == 8'h00)); // R1

    AST_UNMASKED_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(arm_byte)) & ~status_rd) == 8'h00)); // R2

    AST_CLEAR_AND_MASK: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (((status_rd & $past(clr_byte)) == 8'h00)
                    && ((mask_byte & USED) == ($past(ctl_wdata) & USED)))); // R4

    AST_UNMASK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> ((~status_rd & $past(status_rd) & ~$past(ctl_wdata) & USED) == 8'h00)); // R5

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_rd & ~$past(status_rd) & $past(mask_byte)) == 8'h00)); // R6

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> ((~status_rd & $past(status_rd)) == 8'h00)); // R7

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> ((status_rd & $past(ctl_wdata) & $past(ev_byte) & USED) == 8'h00)); // R8

    AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_rd[6] == 1'b0 && mask_byte[6] == 1'b0)); // R9
endmodule

bind endflag_ctrl endflag_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .short_end (short_end),
    .long_end  (long_end),
    .status_rd (status_rd),
    .mask_byte (mask_byte)
);

// File: tb/test_endflag_ctrl.sv
`timescale 1ns/1ps
module test_endflag_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [5:0] short_end = 6'h00;
    logic       long_end = 1'b0;
    logic [7:0] status_rd;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_flag = 8'h00;  // model flags, byte layout
    logic [7:0] m_mask = 8'h00;  // model masks, byte layout

    always #4 clk = ~clk;        // 125 MHz

    endflag_ctrl i_endflag_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .short_end (short_end),
        .long_end  (long_end),
        .status_rd (status_rd)
    );

    // Next flag state, from R2 R4 R6 R7 R8 R10: bit 6 never used (R9).
    function automatic logic [7:0] nxt_flag(input logic [7:0] f, input logic [7:0] m,
                                            input logic w, input logic [7:0] d,
                                            input logic [7:0] e);
        logic [7:0] clr;
        clr = w ? (d & 8'hBF) : 8'h00;
        return ((f | (e & ~m)) & ~clr) & 8'hBF;
    endfunction

    function automatic logic [7:0] nxt_mask(input logic [7:0] m, input logic w,
                                            input logic [7:0] d);
        return w ? (d & 8'hBF) : m;
    endfunction

    task automatic check(input string req);
        n_cmp++;
        if (status_rd !== m_flag) begin
            n_bad++;
            $display("FAIL %s: status_rd actual %02h expected %02h", req, status_rd, m_flag);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare.
    task automatic step(input logic w, input logic [7:0] d, input logic [5:0] se,
                        input logic le, input string req);
        logic [7:0] e;
        ctl_wr = w; ctl_wdata = d; short_end = se; long_end = le;
        e = {le, 1'b0, se};
        m_flag = nxt_flag(m_flag, m_mask, w, d, e);
        m_mask = nxt_mask(m_mask, w, d);
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = 8'h00; short_end = 6'h00; long_end = 1'b0;
        check(req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset status");

        // R1: masks reset to 0, so a pulse sets right away. R3 bit map per channel.
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 8'h00, 6'(1 << k), 1'b0, "R3 short channel bit");
        end
        step(1'b0, 8'h00, 6'h00, 1'b1, "R2 R3 long channel bit 7");
        step(1'b0, 8'h00, 6'h00, 1'b0, "R9 bit6 zero");

        // R7 sticky through idle and repeat pulses.
        repeat (4) step(1'b0, 8'h00, 6'h3F, 1'b1, "R7 sticky");

        // R4 clear and mask channel 1 and long.
        step(1'b1, 8'h81, 6'h00, 1'b0, "R4 clear selected");
        step(1'b0, 8'h00, 6'h01, 1'b1, "R6 masked ignored");

        // R5 unmask keeps flags, then pulses set again.
        step(1'b1, 8'h00, 6'h00, 1'b0, "R5 unmask keeps flags");
        step(1'b0, 8'h00, 6'h01, 1'b1, "R5 unmasked sets");

        // R8 clear wins on channel 2.
        step(1'b1, 8'h02, 6'h02, 1'b0, "R8 clear wins");
        // R10 write 0 with pulse while masked: old mask rules.
        step(1'b1, 8'h00, 6'h02, 1'b0, "R10 old mask rules");
        step(1'b0, 8'h00, 6'h02, 1'b0, "R10 next pulse sets");
        // R10 write 1 to another bit while pulsing an unmasked channel.
        step(1'b1, 8'h04, 6'h08, 1'b0, "R10 unmasked pulse with write");

        // R9 control bit 6 ignored.
        step(1'b1, 8'h40, 6'h00, 1'b0, "R9 bit6 write ignored");
        step(1'b0, 8'h00, 6'h3F, 1'b1, "R9 bit6 status zero");

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic w;
            w = ($urandom % 4) == 0;
            step(w, 8'($urandom), 6'($urandom & $urandom), ($urandom % 3) == 0,
                 "R2 R6 R7 random");
        end

        // R1 reset mid-run.
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_flag = 8'h00; m_mask = 8'h00;
        check("R1 reset again");
        step(1'b0, 8'h00, 6'h3F, 1'b1, "R1 masks cleared by reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule